// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block gathers interrupt requests from a wide bank of GPIO pad inputs and steers any eight of them onto eight channel lines that feed a parent interrupt controller. Each channel picks one pad through an 8-bit select field. The chosen signal then passes through a synchroniser, a programmable glitch filter and a trigger stage. The parent controller only understands active-high levels and rising edges. The trigger stage therefore turns every request type into one of those two forms. Active-low levels and falling edges are inverted, and each qualifying edge becomes a one-cycle pulse.

Software sets the block up through a 32-bit word register interface. The registers are: a trigger word, two pad-select words with four channels packed into each, and a filter word with a 4-bit field for each channel. Deciding which channel serves which pad is left to software.

Top module: `gpio_irq_router`

## Requirements
- R1: Register map, by byte address: 0x00 trigger, 0x04 pad select for channels 0..3, 0x08 pad select for channels 4..7, 0x0C filter. Reads of any other address return zero. Writes to other addresses change nothing. Trigger bits 24..30 always read zero. A write is visible on `bus_rdata` and in channel behaviour from the clock edge that captures it.
- R2: The select field of channel c is 8 bits wide and starts at bit (c mod 4)*8 of its select word. Take a pad that changes just before clock edge k, with the filter bypassed and level mode selected. The change reaches the channel output after edge k+2: two synchroniser flops, then the filter stage.
- R3: A select value at or above `NUM_PADS` feeds a constant 0 into that channel.
- R4: Level mode applies when trigger bit c (edge) and bit 8+c (both-edge) are both clear. The output follows the filtered input, inverted when trigger bit 16+c is set.
- R5: Single-edge mode applies when bit c is set and bit 8+c is clear. The output is a one-cycle high pulse on each rising transition of the filtered input. When bit 16+c is set, the pulse comes on each falling transition instead.
- R6: Both-edge mode applies when bit 8+c is set. Every transition of the filtered input gives a one-cycle pulse, whatever bits c and 16+c hold.
- R7: The filter field of channel c sits at bits c*4+3..c*4 of the filter word. A value of 0 passes the synchronised input straight through. A value N from 1 to 15 updates the filtered value only after N consecutive samples that differ from it. A differing run shorter than N is dropped.
- R8: With `HAS_GLOBAL_EN` set, trigger bit 31 gates all eight outputs, and all outputs are held low while that bit is 0.
- R9: After reset every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PADS | Asynchronous pad request inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address, shared by reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| irq_out | output | 8 | Active-high channel requests to the parent controller |

## Verification
Most faults in this block come from wrong state in the filter counter, the filtered value or the previous-sample flop. Such a fault shows up at a channel output within one to sixteen cycles of the next transition on the selected pad. It appears as a pulse that is missing, doubled or one cycle late, or as a level with the wrong sense. For that reason the bench compares every output against a behavioural model on every cycle. Register decoding faults show up at once on the readback port, and one cycle later as a wrong pad or mode on a channel.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NUM_PADS      = 256,
  parameter bit HAS_GLOBAL_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [7:0]          irq_out
);
  localparam int CH       = 8;
  localparam int SEL_W    = 8;
  localparam int FW       = 4;
  localparam int SEL_SPAN = 1 << SEL_W;
  localparam logic [31:0] TRIG_MASK = HAS_GLOBAL_EN ? 32'h80FF_FFFF : 32'h00FF_FFFF;

  logic [31:0] trig_q, sel_lo_q, sel_hi_q, filt_cfg_q;
  logic [NUM_PADS-1:0] meta_q, sync_q;
  logic [SEL_SPAN-1:0] pads_ext;
  logic [CH-1:0] raw, filt_q, prev_q;
  logic gen_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= '0;
      sel_lo_q   <= '0;
      sel_hi_q   <= '0;
      filt_cfg_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h00: trig_q     <= bus_wdata & TRIG_MASK;
        8'h04: sel_lo_q   <= bus_wdata;
        8'h08: sel_hi_q   <= bus_wdata;
        8'h0C: filt_cfg_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = trig_q;
      8'h04:   bus_rdata = sel_lo_q;
      8'h08:   bus_rdata = sel_hi_q;
      8'h0C:   bus_rdata = filt_cfg_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign pads_ext = SEL_SPAN'(sync_q);
  assign gen_on   = HAS_GLOBAL_EN ? trig_q[31] : 1'b1;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    logic [FW-1:0]    lim, run_q;
    logic             f_q, p_q, cur, old, hit;

    if (c < 4) begin : g_lo
      assign sel = sel_lo_q[c*SEL_W +: SEL_W];
    end else begin : g_hi
      assign sel = sel_hi_q[(c-4)*SEL_W +: SEL_W];
    end

    assign lim    = filt_cfg_q[c*FW +: FW];
    assign raw[c] = pads_ext[sel];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q   <= 1'b0;
        p_q   <= 1'b0;
        run_q <= '0;
      end else begin
        p_q <= f_q;
        if (lim == '0) begin
          f_q   <= raw[c];
          run_q <= '0;
        end else if (raw[c] == f_q) begin
          run_q <= '0;
        end else if ({1'b0, run_q} + 5'd1 >= {1'b0, lim}) begin
          f_q   <= raw[c];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end

    assign filt_q[c] = f_q;
    assign prev_q[c] = p_q;

    assign cur = f_q ^ trig_q[16+c];
    assign old = p_q ^ trig_q[16+c];
    assign hit = trig_q[8+c] ? (f_q ^ p_q) :
                 trig_q[c]   ? (cur & ~old) : cur;
    assign irq_out[c] = gen_on & hit;
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter bit HAS_GLOBAL_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] trig_q,
  input logic [7:0]  raw,
  input logic [7:0]  filt_q,
  input logic [31:0] filt_cfg_q,
  input logic [7:0]  irq_out
);
  logic gen;
  assign gen = HAS_GLOBAL_EN ? trig_q[31] : 1'b1;

  a_r8_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_GLOBAL_EN && !trig_q[31]) |-> (irq_out == 8'h00));

  for (genvar c = 0; c < 8; c++) begin : g_c
    a_r7_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_cfg_q[c*4 +: 4] == 4'd0 && $past(filt_cfg_q[c*4 +: 4]) == 4'd0)
      |-> (filt_q[c] == $past(raw[c])));

    a_r7_change_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q[c]) |-> (filt_q[c] == $past(raw[c])));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[c] && trig_q[c] && !trig_q[8+c])
      |=> (!irq_out[c] || !$stable(trig_q)));

    a_r6_any_transition: assert property (@(posedge clk) disable iff (!rst_n)
      (gen && trig_q[8+c] && !$stable(filt_q[c])) |-> irq_out[c]);
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.HAS_GLOBAL_EN(HAS_GLOBAL_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_q(trig_q), .raw(raw),
  .filt_q(filt_q), .filt_cfg_q(filt_cfg_q), .irq_out(irq_out)
);

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
  localparam int NP = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [7:0]    irq_out;

  gpio_irq_router #(.NUM_PADS(NP), .HAS_GLOBAL_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit compare_on = 1'b0;
  bit gen_phase_off = 1'b0;
  string ch_req [8] = '{"R4", "R4", "R5", "R5", "R3", "R6", "R7", "R7"};

  // behavioural reference model
  logic [NP-1:0] m_s1 = '0, m_s2 = '0;
  logic [31:0] m_trig = '0, m_sel_lo = '0, m_sel_hi = '0, m_fcfg = '0;
  bit m_filt [8];
  bit m_prev [8];
  int m_cnt  [8];

  function automatic int sel_of(int c);
    return (c < 4) ? int'((m_sel_lo >> (c*8)) & 32'hFF) : int'((m_sel_hi >> ((c-4)*8)) & 32'hFF);
  endfunction

  function automatic bit model_out(int c);
    bit both, edg, inv, a, b;
    if (!m_trig[31]) return 1'b0;
    both = m_trig[8+c]; edg = m_trig[c]; inv = m_trig[16+c];
    a = m_filt[c] ^ inv; b = m_prev[c] ^ inv;
    if (both) return m_filt[c] != m_prev[c];
    if (edg) return a && !b;
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0;
      m_trig = '0; m_sel_lo = '0; m_sel_hi = '0; m_fcfg = '0;
      for (int c = 0; c < 8; c++) begin m_filt[c] = 0; m_prev[c] = 0; m_cnt[c] = 0; end
    end else begin
      for (int c = 0; c < 8; c++) begin
        int s, n; bit r;
        s = sel_of(c);
        r = (s < NP) ? m_s2[s] : 1'b0;
        n = int'((m_fcfg >> (c*4)) & 32'hF);
        m_prev[c] = m_filt[c];
        if (n == 0) begin m_filt[c] = r; m_cnt[c] = 0; end
        else if (r == m_filt[c]) m_cnt[c] = 0;
        else begin
          m_cnt[c]++;
          if (m_cnt[c] >= n) begin m_filt[c] = r; m_cnt[c] = 0; end
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_trig   = bus_wdata & 32'h80FF_FFFF;
          8'h04: m_sel_lo = bus_wdata;
          8'h08: m_sel_hi = bus_wdata;
          8'h0C: m_fcfg   = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      for (int c = 0; c < 8; c++) begin
        bit e;
        e = model_out(c);
        checks++;
        if (irq_out[c] !== e) begin
          errors++;
          $display("FAIL %s ch%0d t=%0t irq_out=%b expected=%b",
                   gen_phase_off ? "R8" : ch_req[c], c, $time, irq_out[c], e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual=%08h expected=%08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic check_bit(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  localparam int PADS [8] = '{5, 17, 100, 199, 250, 42, 7, 150};

  task automatic toggle_run(input int cycles, input int odds);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++)
        if (PADS[c] < NP && ($urandom % odds) == 0) pad_in[PADS[c]] = ~pad_in[PADS[c]];
      pad_in[3] = $urandom % 2;
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    for (int c = 0; c < 8; c++) check_bit(irq_out[c], 1'b0, "R9", "reset output");
    rst_n = 1'b1;
    rd_check(8'h00, 32'h0, "R9");
    rd_check(8'h04, 32'h0, "R9");
    rd_check(8'h08, 32'h0, "R9");
    rd_check(8'h0C, 32'h0, "R9");
    compare_on = 1'b1;

    // R1: writable mask, unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF);
    rd_check(8'h00, 32'h80FF_FFFF, "R1");
    wr(8'h10, 32'hDEAD_BEEF);
    rd_check(8'h10, 32'h0, "R1");
    rd_check(8'h0C, 32'h0, "R1");
    wr(8'h00, 32'h0);

    // R2 field packing: ch0=5 ch1=17 ch2=100 ch3=199 | ch4=250 ch5=42 ch6=7 ch7=150
    wr(8'h04, {8'd199, 8'd100, 8'd17, 8'd5});
    wr(8'h08, {8'd150, 8'd7, 8'd42, 8'd250});
    rd_check(8'h04, 32'hC764_1105, "R2");
    rd_check(8'h08, 32'h9607_2AFA, "R2");
    wr(8'h0C, 32'hF300_0000);
    rd_check(8'h0C, 32'hF300_0000, "R7");
    wr(8'h00, 32'h803A_206C);
    rd_check(8'h00, 32'h803A_206C, "R1");
    repeat (4) @(negedge clk);
    // R3: ch4 reads 0 inverted -> level high
    check_bit(irq_out[4], 1'b1, "R3", "out-of-range select inverted level");
    check_bit(irq_out[1], 1'b1, "R4", "inverted low level idle");

    // R2 latency: pad 5 rises, output after edge k+2
    @(negedge clk); pad_in[5] = 1'b1;
    @(negedge clk); #1 check_bit(irq_out[0], 1'b0, "R2", "after edge k");
    @(negedge clk); #1 check_bit(irq_out[0], 1'b0, "R2", "after edge k+1");
    @(negedge clk); #1 check_bit(irq_out[0], 1'b1, "R2", "after edge k+2");

    // R7: short glitch on pad 7 (filter 3) is dropped
    @(negedge clk); pad_in[7] = 1'b1;
    repeat (2) @(negedge clk); pad_in[7] = 1'b0;
    repeat (8) begin @(negedge clk); #1 check_bit(irq_out[6], 1'b0, "R7", "glitch suppressed"); end
    @(negedge clk); pad_in[7] = 1'b1;
    repeat (6) @(negedge clk);

    // R5, R6: falling edge on pad 199, any edge on pad 42
    @(negedge clk); pad_in[199] = 1'b1; pad_in[42] = 1'b1;
    repeat (5) @(negedge clk);
    @(negedge clk); pad_in[199] = 1'b0; pad_in[42] = 1'b0;
    repeat (5) @(negedge clk);

    toggle_run(2000, 4);
    toggle_run(2000, 40);

    // R8: global enable cleared
    wr(8'h00, 32'h003A_206C);
    gen_phase_off = 1'b1;
    toggle_run(400, 4);
    repeat (2) @(negedge clk);
    gen_phase_off = 1'b0;
    wr(8'h00, 32'h803A_206C);

    // swap modes: all level, no filters, then all both-edge
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h80FF_0000);
    toggle_run(500, 3);
    wr(8'h00, 32'h8000_FF00);
    toggle_run(500, 3);

    compare_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule